// File: doc/BRIEF.md
# Packet-Aware Queue Read Sequencer

This block drives the read side of a multi-queue packet FIFO. Each cycle it decides whether to read and from which queue. It watches one active-low ready bit per queue. A ready bit is low while that queue holds at least one complete packet whose first word has not been read yet. The block also watches three tag bits that travel with the word currently at the head of the selected queue: start of packet, end of packet and almost end of packet.

Once a packet has started, it is read to completion without a change of queue. The almost-end tag sits a known number of words ahead of the end word. That distance is a run-time input, and the sequencer uses it to count down to the last word. It pulses a select strobe while the second-to-last word is being read. The end word is read on the next cycle, and the first word of the next queue's packet on the cycle after that, so there is no gap between packets. The next queue is picked round-robin among the ready queues, starting after the current one.

The FIFO presents its head word combinationally: the tags on the inputs belong to the word that `rd_en` pops at the next rising edge. Packet counting and storage live in the FIFO.

Top module: `pkt_rd_seq`

## Requirements
- R1: After reset `rd_en` is 0 and `q_sel` is NQ-1. `sel_stb` stays 0 as long as no `qrdy_n` bit is low.
- R2: With no packet in progress and at least one ready queue, `sel_stb` is 1 in a cycle where `rd_en` is 0. It names the lowest-numbered ready queue above the last one served, wrapping past NQ-1 to 0. On the next cycle `rd_en` is 1 and `q_sel` holds that queue.
- R3: Once reading starts, `rd_en` stays 1 and `q_sel` stays unchanged until a word with `rd_eop` (tag bit 35) is read at or after the packet's first `rd_sop` (tag bit 34). Further start tags inside the packet are ignored. An end tag seen before the start tag is ignored.
- R4: When a word carrying `rd_aeop` (tag bit 33) is read with `lead_cnt` = N (1 to 15), `sel_stb` pulses on the read N-1 words later. If the tag is N words before the end word, that read is the second-to-last word.
- R5: If `sel_stb` pulses on the second-to-last word, the end word is read from the old queue on the next cycle. On the cycle after that, `rd_en` is still 1 and `q_sel` holds the new queue.
- R6: The next queue is the first ready queue found counting upward from the current queue plus one, wrapping from NQ-1 to 0.
- R7: If the current queue is the only ready queue, it is chosen again and its next packet follows without a gap.
- R8: If no queue is ready when the countdown reaches one, no strobe is given and `rd_en` is 0 on the cycle after the end word.
- R9: A packet without an almost-end tag ends with `rd_en` at 0 for the one cycle after its end word. In that cycle `sel_stb` pulses if a queue is ready, and reads resume on the following cycle.
- R10: If the strobe comes earlier than the second-to-last word, reads continue from the current queue until the end word. The new queue is read on the next cycle.
- R11: A queue is selected only while its `qrdy_n` bit is 0.
- R12: If the countdown reaches one on the end word itself, `sel_stb` pulses on that cycle and the new queue is read on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qrdy_n | input | NQ | Per-queue packet ready, low = complete packet waiting |
| rd_sop | input | 1 | Start-of-packet tag of the head word of `q_sel` |
| rd_eop | input | 1 | End-of-packet tag of the head word of `q_sel` |
| rd_aeop | input | 1 | Almost-end tag of the head word of `q_sel` |
| lead_cnt | input | LW | Words from almost-end tag to end tag (1 to 15) |
| rd_en | output | 1 | Pop the head word of `q_sel` at the next edge |
| q_sel | output | $clog2(NQ) | Queue being read |
| sel_stb | output | 1 | One-cycle strobe announcing a queue selection |

## Verification
The bench builds the block with the default NQ = 8 and LW = 4. Eight queues let the round-robin search wrap from queue 6 past 7 to queue 1. A 4-bit lead input lets the bench run the shortest lead of 1 and the longest of 15, as well as 2 and 3. With these values the bench covers the gap-free switch, a strobe that lands on the end word, an early strobe that must wait for the end word, and a stray end tag at a queue head.

// File: rtl/pkt_rd_seq_pkg.sv
package pkt_rd_seq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic aeop;
    logic eop;
    logic sop;
  } pkt_tag_t;

endpackage

// File: rtl/pkt_rd_rr_pick.sv
module pkt_rd_rr_pick #(
  parameter  int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [NQ-1:0] ready,
  input  logic [QW-1:0] base,
  output logic          found,
  output logic [QW-1:0] pick
);

  // queue index reached by stepping off positions above base, modulo NQ
  function automatic logic [QW-1:0] wrap_add(input logic [QW-1:0] b, input int off);
    int s;
    s = (int'(b) + off) % NQ;
    return QW'(s);
  endfunction

  // ready bits rotated so that position 0 is the queue just above base
  logic [NQ-1:0] rot;

  generate
    for (genvar i = 0; i < NQ; i++) begin : g_rot
      assign rot[i] = ready[wrap_add(base, i + 1)];
    end
  endgenerate

  always_comb begin
    found = |rot;
    pick  = base;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (rot[i]) pick = wrap_add(base, i + 1);
    end
  end

endmodule

// File: rtl/pkt_rd_lead_cnt.sv
module pkt_rd_lead_cnt #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  input  logic          aeop,
  input  logic [LW-1:0] lead,
  output logic          at_one
);

  // words still to come after the current read
  function automatic logic [LW-1:0] eff_count(input logic tag, input logic [LW-1:0] ld,
                                              input logic [LW-1:0] cnt);
    return tag ? ld : cnt;
  endfunction

  logic [LW-1:0] cnt_q;
  logic [LW-1:0] cnt_eff;

  assign cnt_eff = eff_count(aeop, lead, cnt_q);
  assign at_one  = adv && (cnt_eff == LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= (cnt_eff != '0) ? cnt_eff - LW'(1) : '0;
    end
  end

endmodule

// File: rtl/pkt_rd_ctrl.sv
module pkt_rd_ctrl
  import pkt_rd_seq_pkg::*;
#(
  parameter  int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pkt_tag_t      tag,
  input  logic          found,
  input  logic [QW-1:0] pick,
  input  logic          at_one,
  output logic          rd_en,
  output logic [QW-1:0] cur_q,
  output logic          sel_stb,
  output logic          adv,
  output logic          clr,
  output logic          fire,
  output logic          idle_go,
  output logic          eop_hit
);

  seq_state_e    st_q;
  logic [QW-1:0] nxt_q;
  logic          pend_q;
  logic          seen_sop_q;
  logic          run;

  assign run     = (st_q == SEQ_RUN);
  assign rd_en   = run;
  // an end tag counts only once the packet start has been read
  assign eop_hit = run && tag.eop && (seen_sop_q || tag.sop);
  assign fire    = run && !pend_q && at_one && found;
  assign idle_go = !run && found;
  assign sel_stb = fire || idle_go;
  assign adv     = run;
  assign clr     = eop_hit || !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SEQ_IDLE;
      cur_q      <= QW'(NQ - 1);
      nxt_q      <= '0;
      pend_q     <= 1'b0;
      seen_sop_q <= 1'b0;
    end else if (!run) begin
      pend_q     <= 1'b0;
      seen_sop_q <= 1'b0;
      if (idle_go) begin
        st_q  <= SEQ_RUN;
        cur_q <= pick;
      end
    end else begin
      if (tag.sop) seen_sop_q <= 1'b1;
      if (fire) begin
        nxt_q  <= pick;
        pend_q <= 1'b1;
      end
      if (eop_hit) begin
        seen_sop_q <= 1'b0;
        if (pend_q) begin
          cur_q  <= nxt_q;
          pend_q <= 1'b0;
        end else if (fire) begin
          cur_q  <= pick;
          pend_q <= 1'b0;
        end else begin
          st_q <= SEQ_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/pkt_rd_seq.sv
module pkt_rd_seq
  import pkt_rd_seq_pkg::*;
#(
  parameter  int NQ = 8,
  parameter  int LW = 4,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] qrdy_n,
  input  logic          rd_sop,
  input  logic          rd_eop,
  input  logic          rd_aeop,
  input  logic [LW-1:0] lead_cnt,
  output logic          rd_en,
  output logic [QW-1:0] q_sel,
  output logic          sel_stb
);

  pkt_tag_t      tag;
  logic          found;
  logic [QW-1:0] pick;
  logic          at_one;
  logic          adv;
  logic          clr;
  logic          fire;
  logic          idle_go;
  logic          eop_hit;
  logic [QW-1:0] cur_q;

  assign tag = '{aeop: rd_aeop, eop: rd_eop, sop: rd_sop};

  pkt_rd_rr_pick #(.NQ(NQ)) u_pick (
    .ready (~qrdy_n),
    .base  (cur_q),
    .found (found),
    .pick  (pick)
  );

  pkt_rd_lead_cnt #(.LW(LW)) u_lead (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .clr    (clr),
    .aeop   (tag.aeop),
    .lead   (lead_cnt),
    .at_one (at_one)
  );

  pkt_rd_ctrl #(.NQ(NQ)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tag     (tag),
    .found   (found),
    .pick    (pick),
    .at_one  (at_one),
    .rd_en   (rd_en),
    .cur_q   (cur_q),
    .sel_stb (sel_stb),
    .adv     (adv),
    .clr     (clr),
    .fire    (fire),
    .idle_go (idle_go),
    .eop_hit (eop_hit)
  );

  assign q_sel = cur_q;

endmodule

// File: rtl/pkt_rd_seq_chk.sv
module pkt_rd_seq_chk #(
  parameter  int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NQ-1:0] qrdy_n,
  input logic          rd_en,
  input logic [QW-1:0] q_sel,
  input logic          sel_stb,
  input logic          eop_hit
);

  logic [NQ-1:0] rdy_n_d;

  always_ff @(posedge clk) rdy_n_d <= qrdy_n;

  // R3
  pkt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !eop_hit |=> rd_en && $stable(q_sel));

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb && !rd_en |=> rd_en);

  // R11
  ready_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb && !rd_en |=> !rdy_n_d[q_sel]);

  // R5
  gap_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb && rd_en && !eop_hit ##1 eop_hit |=> rd_en);

  // R4
  single_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb && rd_en && !eop_hit |=> !sel_stb);

endmodule

bind pkt_rd_seq pkt_rd_seq_chk #(.NQ(NQ)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .qrdy_n  (qrdy_n),
  .rd_en   (rd_en),
  .q_sel   (q_sel),
  .sel_stb (sel_stb),
  .eop_hit (eop_hit)
);

// File: tb/pkt_rd_seq_bench.sv
`timescale 1ns/1ps
module pkt_rd_seq_bench;
  localparam int NQ  = 8;
  localparam int LW  = 4;
  localparam int QW  = 3;
  localparam int DEP = 64;
  localparam int LOG = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NQ-1:0] qrdy_n = '1;
  logic          rd_sop = 1'b0;
  logic          rd_eop = 1'b0;
  logic          rd_aeop = 1'b0;
  logic [LW-1:0] lead_cnt = '0;
  logic          rd_en;
  logic [QW-1:0] q_sel;
  logic          sel_stb;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pkt_rd_seq #(.NQ(NQ), .LW(LW)) u_pkt_rd_seq (
    .clk(clk), .rst_n(rst_n), .qrdy_n(qrdy_n), .rd_sop(rd_sop), .rd_eop(rd_eop),
    .rd_aeop(rd_aeop), .lead_cnt(lead_cnt), .rd_en(rd_en), .q_sel(q_sel), .sel_stb(sel_stb)
  );

  // queue model: tag bit 0 start, bit 1 end, bit 2 almost-end
  logic [2:0] mem [NQ][DEP];
  int wp [NQ];
  int rp [NQ];
  int avail [NQ];
  bit inpk [NQ];

  logic          lg_rd  [LOG];
  logic          lg_stb [LOG];
  logic [QW-1:0] lg_q   [LOG];
  int   logk = 0;
  logic prev_rd = 1'b0;
  logic [QW-1:0] prev_q = '0;

  task automatic pop(input int q);
    logic [2:0] t;
    t = mem[q][rp[q]];
    rp[q]++;
    if (t[0] && !inpk[q]) begin
      inpk[q] = 1'b1;
      avail[q]--;
    end else if (t[1] && inpk[q]) begin
      inpk[q] = 1'b0;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_rd = 1'b0;
        logk = 0;
      end else if (prev_rd) begin
        pop(int'(prev_q));
      end
      for (int q = 0; q < NQ; q++) qrdy_n[q] = !(avail[q] > 0);
      if (rp[q_sel] < wp[q_sel]) {rd_aeop, rd_eop, rd_sop} = mem[q_sel][rp[q_sel]];
      else {rd_aeop, rd_eop, rd_sop} = 3'b000;
      #1;
      if (rst_n) begin
        if (logk < LOG) begin
          lg_rd[logk]  = rd_en;
          lg_stb[logk] = sel_stb;
          lg_q[logk]   = q_sel;
        end
        logk++;
        prev_rd = rd_en;
        prev_q  = q_sel;
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic exp_rd(input int k, input logic v, input string req);
    chk(lg_rd[k] == v, req, $sformatf("rd_en at cycle %0d", k), int'(lg_rd[k]), int'(v));
  endtask

  task automatic exp_stb(input int k, input logic v, input string req);
    chk(lg_stb[k] == v, req, $sformatf("sel_stb at cycle %0d", k), int'(lg_stb[k]), int'(v));
  endtask

  task automatic exp_q(input int k, input int v, input string req);
    chk(lg_rd[k] && int'(lg_q[k]) == v, req, $sformatf("read queue at cycle %0d", k),
        lg_rd[k] ? int'(lg_q[k]) : -1, v);
  endtask

  task automatic begin_reset(input int lead);
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    lead_cnt = LW'(lead);
    for (int q = 0; q < NQ; q++) begin
      wp[q] = 0; rp[q] = 0; avail[q] = 0; inpk[q] = 1'b0;
    end
  endtask

  task automatic end_reset();
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  task automatic wait_log(input int n);
    while (logk < n) @(posedge clk);
  endtask

  // d = words from almost-end tag to end word (0 = none); xsop adds a start tag on word 2
  task automatic push_pkt(input int q, input int len, input int d, input bit xsop);
    for (int i = 0; i < len; i++) begin
      logic [2:0] t;
      t = 3'b000;
      if (i == 0) t[0] = 1'b1;
      if (i == len - 1) t[1] = 1'b1;
      if (d > 0 && i == len - 1 - d) t[2] = 1'b1;
      if (xsop && i == 2) t[0] = 1'b1;
      mem[q][wp[q]] = t;
      wp[q]++;
    end
    avail[q]++;
  endtask

  task automatic push_word(input int q, input logic [2:0] t);
    mem[q][wp[q]] = t;
    wp[q]++;
  endtask

  task automatic t_reset();
    begin_reset(3);
    end_reset();
    wait_log(4);
    for (int k = 0; k < 3; k++) begin
      exp_rd(k, 1'b0, "R1");
      exp_stb(k, 1'b0, "R1");
      chk(lg_q[k] == QW'(NQ - 1), "R1", "q_sel after reset", int'(lg_q[k]), NQ - 1);
    end
  endtask

  task automatic t_idle();
    begin_reset(3);
    push_pkt(2, 4, 0, 1'b0);
    push_pkt(6, 4, 0, 1'b0);
    end_reset();
    wait_log(12);
    exp_stb(0, 1'b1, "R2");
    exp_rd(0, 1'b0, "R2");
    exp_q(1, 2, "R2 R11");
    exp_q(4, 2, "R3");
    exp_rd(5, 1'b0, "R9");
    exp_stb(5, 1'b1, "R9");
    exp_q(6, 6, "R9 R6");
    exp_rd(10, 1'b0, "R8");
    exp_stb(10, 1'b0, "R11");
  endtask

  task automatic t_lookahead();
    begin_reset(3);
    push_pkt(1, 8, 3, 1'b0);
    push_pkt(3, 5, 3, 1'b0);
    push_pkt(6, 6, 3, 1'b0);
    end_reset();
    wait_log(22);
    for (int k = 1; k <= 8; k++) exp_q(k, 1, "R3");
    exp_stb(6, 1'b0, "R4");
    exp_stb(7, 1'b1, "R4");
    exp_stb(8, 1'b0, "R4");
    exp_q(8, 1, "R5");
    exp_q(9, 3, "R5 R6");
    exp_stb(12, 1'b1, "R4");
    exp_q(13, 3, "R5");
    exp_q(14, 6, "R6");
    for (int k = 14; k <= 19; k++) exp_stb(k, 1'b0, "R8");
    exp_q(19, 6, "R8");
    exp_rd(20, 1'b0, "R8");
  endtask

  task automatic t_keep();
    begin_reset(2);
    push_pkt(3, 6, 2, 1'b0);
    push_pkt(3, 6, 2, 1'b0);
    end_reset();
    wait_log(15);
    exp_stb(5, 1'b1, "R7");
    exp_q(6, 3, "R7");
    exp_q(7, 3, "R7");
    exp_stb(10, 1'b0, "R8");
    exp_q(12, 3, "R7");
    exp_rd(13, 1'b0, "R8");
  endtask

  task automatic t_wrap();
    begin_reset(3);
    push_pkt(6, 10, 3, 1'b0);
    end_reset();
    wait_log(3);
    push_pkt(1, 4, 0, 1'b0);
    push_pkt(4, 4, 0, 1'b0);
    wait_log(18);
    exp_stb(9, 1'b1, "R4");
    exp_q(10, 6, "R5");
    exp_q(11, 1, "R6");
    exp_rd(15, 1'b0, "R9");
    exp_q(16, 4, "R9");
  endtask

  task automatic t_early();
    begin_reset(2);
    push_pkt(0, 9, 5, 1'b1);
    push_word(5, 3'b010);
    push_pkt(5, 4, 0, 1'b0);
    end_reset();
    wait_log(17);
    exp_stb(5, 1'b1, "R10");
    for (int k = 1; k <= 9; k++) exp_q(k, 0, "R10 R3");
    exp_q(10, 5, "R10");
    for (int k = 11; k <= 14; k++) exp_q(k, 5, "R3");
    exp_rd(15, 1'b0, "R3");
  endtask

  task automatic t_eop_fire();
    begin_reset(2);
    push_pkt(2, 5, 1, 1'b0);
    push_pkt(7, 4, 0, 1'b0);
    end_reset();
    wait_log(10);
    exp_stb(4, 1'b0, "R12");
    exp_stb(5, 1'b1, "R12");
    exp_q(5, 2, "R12");
    exp_q(6, 7, "R12");
  endtask

  task automatic t_lead1();
    begin_reset(1);
    push_pkt(4, 4, 1, 1'b0);
    push_pkt(5, 4, 0, 1'b0);
    end_reset();
    wait_log(8);
    exp_stb(2, 1'b0, "R4");
    exp_stb(3, 1'b1, "R4");
    exp_q(4, 4, "R5");
    exp_q(5, 5, "R5");
  endtask

  task automatic t_lead15();
    begin_reset(15);
    push_pkt(0, 20, 15, 1'b0);
    push_pkt(1, 4, 0, 1'b0);
    end_reset();
    wait_log(24);
    exp_stb(18, 1'b0, "R4");
    exp_stb(19, 1'b1, "R4");
    exp_q(20, 0, "R5");
    exp_q(21, 1, "R5");
  endtask

  initial begin
    for (int q = 0; q < NQ; q++) begin
      wp[q] = 0; rp[q] = 0; avail[q] = 0; inpk[q] = 1'b0;
    end
    t_reset();
    t_idle();
    t_lookahead();
    t_keep();
    t_wrap();
    t_early();
    t_eop_fire();
    t_lead1();
    t_lead15();
    summary();
    $finish;
  end

endmodule